// File: doc/BRIEF.md
# Phase-Aligned Start Handoff Between Ratio-Locked Clocks

This block carries a start request from a slow clock domain into a fast domain. The fast clock runs at exactly four times the slow rate and is edge-aligned with it, so every slow rising edge falls on one fast rising edge. The raw request comes from a push-button and has no timing relation to either clock. It is synchronized in the slow domain and held there as a sticky slow run flag.

The fast domain must start work on the fast edge that coincides with a slow edge. Work may never start on one of the three fast edges in between. The block finds that edge without using the slow clock as data. A slow-domain register flips on every slow edge. The fast domain watches this register for a change and keeps a phase counter aligned to it. The fast run flag is released only on a phase-one edge, and only after the counter has seen at least one boundary since reset.

Clock generation and debouncing belong to the surrounding design. Reset is synchronous and active-low in both domains.

Top module: `phase_start_xfer`

## Requirements
- R1: While `rst_n` is low, every clock edge clears `slow_start_o`, `fast_start_o` and `phase_o` to zero.
- R2: The button passes through two slow-clock flops and then a registered flag. `slow_start_o` therefore goes high just after the third slow rising edge that follows the button's rise.
- R3: Once high, `slow_start_o` stays high until reset, even after the button is released.
- R4: `phase_o` is 0 in the fast period that follows the fast edge coincident with a slow edge (phase one). It then counts 1, 2, 3 on the next three fast edges and wraps back to 0.
- R5: `fast_start_o` rises only on a phase-one fast edge. Just after its rise, `phase_o` reads 0.
- R6: `fast_start_o` rises exactly four fast edges (one slow period) after the fast edge on which `slow_start_o` rose. Slow-domain logic that sees `slow_start_o` acts on that same edge.
- R7: Once high, `fast_start_o` stays high until reset.
- R8: A button pulse that rises and falls between two slow rising edges has no effect: both start flags stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_slow | input | 1 | Slow clock, rising edges aligned with every fourth fast edge |
| clk_fast | input | 1 | Fast clock, four times the slow rate |
| rst_n | input | 1 | Synchronous active-low reset for both domains |
| start_btn_i | input | 1 | Raw asynchronous start button |
| slow_start_o | output | 1 | Sticky slow-domain run flag |
| fast_start_o | output | 1 | Sticky fast-domain run flag, released on phase one |
| phase_o | output | $clog2(RATIO) | Fast phase index, 0 after the phase-one edge |

## Verification
`slow_start_o` is due three slow rising edges after the button rises. The bench counts those edges and samples 1 ns after each one, so the count is exact. `fast_start_o` is due four fast edges after `slow_start_o`. A monitor numbers every fast rising edge and records the numbers seen at the following falling edge. Those records give the phase-one condition (number divisible by four) and the four-edge gap. `phase_o` is compared at each fast falling edge against that edge number modulo four. For the short pulse, the no-effect check runs five slow periods after the pulse, well past the three-edge window in which it could have registered.

// File: rtl/psx_pkg.sv
// Shared defaults and helpers for the phase-aligned start handoff.
// Assumes: phase counts are small and fit in 32 bits.
package psx_pkg;
    localparam int unsigned PSX_RATIO_DEF = 4;
    localparam int unsigned PSX_SYNC_DEF  = 2;

    // Increment a phase index, wrapping at the given modulus.
    function automatic int unsigned psx_wrap_inc(input int unsigned val,
                                                 input int unsigned modulus);
        return ((val + 32'd1) >= modulus) ? 32'd0 : (val + 32'd1);
    endfunction
endpackage

// File: rtl/psx_btn_sync.sv
// Slow-domain button capture: a chain of STAGES flops resolves the
// asynchronous button, then a sticky flag records the first sighting.
// Assumes: button held across at least one slow rising edge to count.
module psx_btn_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_slow,
    input  logic rst_n,
    input  logic btn_raw,
    output logic start_flag
);
    logic [STAGES-1:0] stage_q;

    // Shift the raw button through the synchronizer chain.
    always_ff @(posedge clk_slow) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= btn_raw;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    // Hold the run flag once the synchronized button is seen.
    always_ff @(posedge clk_slow) begin
        if (!rst_n) start_flag <= 1'b0;
        else        start_flag <= start_flag | stage_q[STAGES-1];
    end
endmodule

// File: rtl/psx_slow_beacon.sv
// Slow-domain beacon: a register that inverts on every slow rising edge,
// so the fast domain can see slow-period boundaries as data changes.
// Assumes: clocks are phase-locked, so no metastability on the sample.
module psx_slow_beacon (
    input  logic clk_slow,
    input  logic rst_n,
    output logic beacon
);
    // Invert once per slow period.
    always_ff @(posedge clk_slow) begin
        if (!rst_n) beacon <= 1'b0;
        else        beacon <= ~beacon;
    end
endmodule

// File: rtl/psx_phase_track.sv
// Fast-domain phase tracker: samples the slow beacon each fast edge.
// A change means the previous edge was phase one, so the counter loads 1.
// Otherwise it increments modulo RATIO. 'locked' sets at the first boundary.
// Assumes: RATIO >= 2; beacon comes from a phase-locked slow register.
module psx_phase_track #(
    parameter int unsigned RATIO = 4,
    parameter int unsigned PW    = 2
) (
    input  logic          clk_fast,
    input  logic          rst_n,
    input  logic          beacon,
    output logic [PW-1:0] phase_q,
    output logic          locked
);
    import psx_pkg::*;

    localparam bit IS_POW2 = ((RATIO & (RATIO - 1)) == 0);

    logic          beacon_seen;
    logic          boundary;
    logic [PW-1:0] phase_inc;

    // Beacon differs from last sample exactly on the edge after phase one.
    assign boundary = beacon ^ beacon_seen;

    // Choose the cheapest wrap for the ratio.
    if (IS_POW2) begin : g_pow2_wrap
        assign phase_inc = phase_q + PW'(1);
    end else begin : g_cmp_wrap
        assign phase_inc = PW'(psx_wrap_inc(32'(phase_q), RATIO));
    end

    // Sample beacon, realign on boundaries, count otherwise.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            beacon_seen <= 1'b0;
            phase_q     <= '0;
            locked      <= 1'b0;
        end else begin
            beacon_seen <= beacon;
            locked      <= locked | boundary;
            phase_q     <= boundary ? PW'(1) : phase_inc;
        end
    end
endmodule

// File: rtl/psx_fast_gate.sv
// Fast-domain release gate: sets the sticky fast run flag on a phase-one
// edge once the tracker is locked and the slow run flag is visible.
// Assumes: slow_start comes from a phase-locked slow register.
module psx_fast_gate #(
    parameter int unsigned RATIO = 4,
    parameter int unsigned PW    = 2
) (
    input  logic          clk_fast,
    input  logic          rst_n,
    input  logic          locked,
    input  logic [PW-1:0] phase,
    input  logic          slow_start,
    output logic          fast_start
);
    logic edge_is_phase_one;

    // Counter at its last value means the coming edge is phase one.
    assign edge_is_phase_one = (phase == PW'(RATIO - 1));

    // Latch the run enable on the first qualifying edge.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) fast_start <= 1'b0;
        else        fast_start <= fast_start |
                                  (locked & edge_is_phase_one & slow_start);
    end
endmodule

// File: rtl/phase_start_xfer.sv
// Top: hands a button start from the slow domain into a ratio-locked fast
// domain, releasing the fast run flag only on slow-aligned fast edges.
// Assumes: clk_fast = RATIO x clk_slow, rising edges aligned; rst_n
// deasserted away from clock edges and held for several slow periods.
module phase_start_xfer #(
    parameter int unsigned RATIO       = psx_pkg::PSX_RATIO_DEF,
    parameter int unsigned SYNC_STAGES = psx_pkg::PSX_SYNC_DEF
) (
    input  logic                     clk_slow,
    input  logic                     clk_fast,
    input  logic                     rst_n,
    input  logic                     start_btn_i,
    output logic                     slow_start_o,
    output logic                     fast_start_o,
    output logic [$clog2(RATIO)-1:0] phase_o
);
    localparam int unsigned PHASE_W = $clog2(RATIO);

    logic beacon;
    logic locked;

    psx_btn_sync #(.STAGES(SYNC_STAGES)) u_btn_sync (
        .clk_slow   (clk_slow),
        .rst_n      (rst_n),
        .btn_raw    (start_btn_i),
        .start_flag (slow_start_o)
    );

    psx_slow_beacon u_beacon (
        .clk_slow (clk_slow),
        .rst_n    (rst_n),
        .beacon   (beacon)
    );

    psx_phase_track #(.RATIO(RATIO), .PW(PHASE_W)) u_phase (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .beacon   (beacon),
        .phase_q  (phase_o),
        .locked   (locked)
    );

    psx_fast_gate #(.RATIO(RATIO), .PW(PHASE_W)) u_gate (
        .clk_fast   (clk_fast),
        .rst_n      (rst_n),
        .locked     (locked),
        .phase      (phase_o),
        .slow_start (slow_start_o),
        .fast_start (fast_start_o)
    );
endmodule

// File: rtl/phase_start_xfer_chk.sv
// Property checker for phase_start_xfer, attached by bind below.
// Assumes: the same clocks and reset as the design.
module phase_start_xfer_chk #(
    parameter int unsigned RATIO = 4,
    parameter int unsigned PW    = 2
) (
    input logic          clk_slow,
    input logic          clk_fast,
    input logic          rst_n,
    input logic          slow_start_o,
    input logic          fast_start_o,
    input logic [PW-1:0] phase_o
);
    import psx_pkg::*;

    localparam int unsigned AW = $clog2(RATIO + 2);

    logic [AW-1:0] ss_age;

    // Count fast edges since slow_start_o went high (saturating).
    always_ff @(posedge clk_fast) begin
        if (!rst_n || !slow_start_o) ss_age <= '0;
        else if (ss_age <= AW'(RATIO)) ss_age <= ss_age + AW'(1);
    end

    a_r1_fast_reset: assert property (@(posedge clk_fast)
        !rst_n |=> (!fast_start_o && phase_o == '0));

    a_r1_slow_reset: assert property (@(posedge clk_slow)
        !rst_n |=> !slow_start_o);

    a_r3_slow_sticky: assert property (@(posedge clk_slow) disable iff (!rst_n)
        slow_start_o |=> slow_start_o);

    a_r4_phase_step: assert property (@(posedge clk_fast) disable iff (!rst_n)
        fast_start_o |=> (32'(phase_o) == psx_wrap_inc(32'($past(phase_o)), RATIO)));

    a_r5_phase_one_rise: assert property (@(posedge clk_fast) disable iff (!rst_n)
        $rose(fast_start_o) |-> (phase_o == '0));

    a_r6_one_period: assert property (@(posedge clk_fast) disable iff (!rst_n)
        $rose(fast_start_o) |-> (ss_age == AW'(RATIO)));

    a_r7_fast_sticky: assert property (@(posedge clk_fast) disable iff (!rst_n)
        fast_start_o |=> fast_start_o);
endmodule

bind phase_start_xfer phase_start_xfer_chk #(
    .RATIO (RATIO),
    .PW    ($clog2(RATIO))
) u_chk (
    .clk_slow     (clk_slow),
    .clk_fast     (clk_fast),
    .rst_n        (rst_n),
    .slow_start_o (slow_start_o),
    .fast_start_o (fast_start_o),
    .phase_o      (phase_o)
);

// File: tb/phase_start_xfer_tb.sv
`timescale 1ns/100ps
module phase_start_xfer_tb;
    logic       clk_slow;
    logic       clk_fast;
    logic       rst_n;
    logic       start_btn_i;
    logic       slow_start_o;
    logic       fast_start_o;
    logic [1:0] phase_o;

    int n_checks = 0;
    int n_fail   = 0;
    int edge_idx = 0;
    int ss_edge  = -1;
    int fs_edge  = -1;
    int fs_phase = -1;
    logic ss_prev = 1'b0;
    logic fs_prev = 1'b0;

    phase_start_xfer u_dut (
        .clk_slow     (clk_slow),
        .clk_fast     (clk_fast),
        .rst_n        (rst_n),
        .start_btn_i  (start_btn_i),
        .slow_start_o (slow_start_o),
        .fast_start_o (fast_start_o),
        .phase_o      (phase_o)
    );

    // 250 MHz fast clock; rising edges at 2, 6, 10, ... ns
    initial begin
        clk_fast = 1'b0;
        #2;
        forever begin
            clk_fast = 1'b1; #2;
            clk_fast = 1'b0; #2;
        end
    end

    // Slow clock at one quarter rate, rising with every fourth fast edge
    initial begin
        clk_slow = 1'b0;
        #2;
        forever begin
            clk_slow = 1'b1; #8;
            clk_slow = 1'b0; #8;
        end
    end

    // Number the fast rising edges (edge 0 at 2 ns)
    always @(posedge clk_fast) edge_idx = edge_idx + 1;

    // Record the fast edge on which each run flag rose
    always @(negedge clk_fast) begin
        if (slow_start_o && !ss_prev) ss_edge = edge_idx - 1;
        if (fast_start_o && !fs_prev) begin
            fs_edge  = edge_idx - 1;
            fs_phase = int'(phase_o);
        end
        ss_prev = slow_start_o;
        fs_prev = fast_start_o;
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reset with outputs checked under reset, then release and settle
    task automatic do_reset();
        @(negedge clk_fast);
        rst_n = 1'b0;
        start_btn_i = 1'b0;
        repeat (3) @(posedge clk_slow);
        #1;
        check("R1 slow_start in reset", int'(slow_start_o), 0);
        check("R1 fast_start in reset", int'(fast_start_o), 0);
        check("R1 phase in reset", int'(phase_o), 0);
        ss_edge = -1;
        fs_edge = -1;
        fs_phase = -1;
        @(negedge clk_fast);
        rst_n = 1'b1;
        repeat (3) @(posedge clk_slow);
    endtask

    // R4: phase index follows fast edge number modulo four
    task automatic t_phase();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk_fast);
            check("R4 phase index", int'(phase_o), (edge_idx - 1) % 4);
        end
    endtask

    // R8: pulse entirely between two slow edges is ignored
    task automatic t_short_pulse();
        @(posedge clk_slow);
        #3  start_btn_i = 1'b1;
        #10 start_btn_i = 1'b0;
        repeat (5) @(posedge clk_slow);
        #1;
        check("R8 slow_start after short pulse", int'(slow_start_o), 0);
        check("R8 fast_start after short pulse", int'(fast_start_o), 0);
    endtask

    // Button at an offset (tenths of ns) from a fast falling edge
    task automatic t_start(input int off_tenths);
        int n;
        int off;
        off = off_tenths;
        if (off % 40 == 20) off++;
        @(negedge clk_fast);
        #(real'(off) / 10.0);
        start_btn_i = 1'b1;
        n = 0;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk_slow);
            #1;
            n++;
            if (slow_start_o) break;
        end
        check("R2 slow edges to slow_start", n, 3);
        @(posedge clk_slow);
        #1 start_btn_i = 1'b0;
        repeat (4) @(posedge clk_slow);
        #1;
        check("R3 slow_start held after release", int'(slow_start_o), 1);
        check("R7 fast_start held", int'(fast_start_o), 1);
        check("R5 rise edge is phase one", fs_edge % 4, 0);
        check("R5 phase after rise", fs_phase, 0);
        check("R6 gap slow->fast edges", fs_edge - ss_edge, 4);
    endtask

    initial begin
        rst_n = 1'b0;
        start_btn_i = 1'b0;
        do_reset();
        t_phase();
        t_short_pulse();
        for (int k = 0; k < 6; k++) begin
            do_reset();
            t_start(int'($urandom_range(1, 159)));
        end
        do_reset();
        t_start(7);
        do_reset();
        t_phase();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run is a failed check
    initial begin
        #800000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule